// File: doc/BRIEF.md
# Gated Beeper Tone Generator

This block turns a single stream of clock-enable pulses into two derived timing products. A free-running prescaler counts the incoming enable pulses. Every second pulse is passed on as a half-rate enable for a display controller, and every sixteenth pulse advances a separate tone counter. The most significant bit of the tone counter is the audio output, a logic-level square wave at one sixteenth of the prescaler's wrap rate. With a 1.2288 MHz enable stream, the display enable runs at 614.4 kHz, the tone counter steps at 76.8 kHz and the tone is 4.8 kHz. Every division uses enables on the one system clock, and no derived clock is created.

A small controller sits on top of the divider. A valid keypress raises a short-beep request and an invalid one raises a long-beep request. The controller then keeps the tone counter running for a fixed number of tone periods. Outside a beep, the tone counter is held cleared, so the output stays low. The short and long lengths are parameters, with defaults of 480 and 2400 periods (100 ms and 500 ms at 4.8 kHz).

Top module: `beep_tone_gen`

## Requirements
- R1: `dispEn` is high only in a cycle where `sysEn` is high and the prescaler count is odd, so it marks every second `sysEn` pulse and is never high in two consecutive cycles.
- R2: The prescaler advances by one on every `sysEn` pulse and wraps at its all-ones value. Requests and beep state never alter it, so `dispEn` keeps its rhythm through any beep activity.
- R3: The tone counter advances only in a cycle where `sysEn` is high and the prescaler is at all-ones. It holds in every other cycle.
- R4: While `beepActive` is low, the tone counter is held at zero and `toneOut` is low.
- R5: `toneOut` is the MSB of the tone counter. After a beep starts it is low for 8 tone steps, then high for 8 tone steps, repeating with a period of 16 tone steps.
- R6: A `reqShort` pulse with `reqLong` low sets `beepActive` in the next cycle. `beepActive` stays high until `SHORT_PERIODS` complete tone periods have ended.
- R7: A `reqLong` pulse sets `beepActive` in the next cycle. `beepActive` stays high until `LONG_PERIODS` complete tone periods have ended.
- R8: A request that arrives during an active beep reloads the duration with the new length and restarts the tone counter from zero. The beep does not end in between.
- R9: When `reqShort` and `reqLong` are high in the same cycle, the long length is loaded.
- R10: A request that arrives in the cycle where the final tone period ends wins. `beepActive` stays high and the new length is loaded.
- R11: During reset, `beepActive`, `toneOut` and the prescaler are cleared. `dispEn` is low while `sysEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sysEn | input | 1 | Base-rate clock-enable pulse (1.2288 MHz rate) |
| reqShort | input | 1 | One-cycle request for a short beep (valid entry) |
| reqLong | input | 1 | One-cycle request for a long beep (invalid entry) |
| dispEn | output | 1 | Half-rate enable pulse for the display controller |
| toneOut | output | 1 | Logic-level square-wave tone, low when silent |
| beepActive | output | 1 | High while a beep is being sounded |

## Verification
The risky overlap is a new request in the same cycle as the tone counter's wrap that ends a beep's last period. The same concern covers a request meeting any wrap, where a reload races a decrement. The bench provokes the overlap directly: its reference model predicts the final wrap and drives a short request into exactly that cycle. The outputs must then show an unbroken `beepActive` and a tone that restarts from its low half. Simultaneous short and long requests, and random requests over a random enable pattern, are judged the same way against the model every cycle.

// File: rtl/beep_pkg.sv
package beep_pkg;

  // Strobes from the beep controller to the tone datapath.
  typedef struct packed {
    logic hold;     // keep the tone counter cleared (no beep)
    logic restart;  // a request this cycle: restart tone phase
  } toneCtl_t;

endpackage

// File: rtl/beep_tone_path.sv
module beep_tone_path
  import beep_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int TONE_W = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sysEn,
  input  toneCtl_t ctl,
  output logic     dispEn,
  output logic     toneOut,
  output logic     periodDone
);

  localparam logic [PRE_W-1:0]  PRE_MAX  = {PRE_W{1'b1}};
  localparam logic [TONE_W-1:0] TONE_MAX = {TONE_W{1'b1}};

  logic [PRE_W-1:0]  preCnt;
  logic [TONE_W-1:0] toneCnt;
  logic              preWrap;
  logic              toneClr;

  // Free-running prescaler: only sysEn moves it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preCnt <= '0;
    else if (sysEn) preCnt <= preCnt + 1'b1;
  end

  assign dispEn  = sysEn & preCnt[0];
  assign preWrap = sysEn & (preCnt == PRE_MAX);
  assign toneClr = ctl.hold | ctl.restart;

  // Clear-gated tone counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        toneCnt <= '0;
    else if (toneClr) toneCnt <= '0;
    else if (preWrap) toneCnt <= toneCnt + 1'b1;
  end

  assign toneOut    = toneCnt[TONE_W-1];
  assign periodDone = preWrap & (toneCnt == TONE_MAX) & ~toneClr;

  // R1: display enable never fires twice in a row
  assert_disp_half_rate_R1: assert property (@(posedge clk) disable iff (!rstN)
    dispEn |=> !dispEn);

  // R3: tone counter holds when there is no prescaler wrap and no clear
  assert_tone_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!preWrap && !toneClr) |=> $stable(toneCnt));

  // R4: a clear leaves the tone output low
  assert_clear_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    toneClr |=> !toneOut);

endmodule

// File: rtl/beep_ctrl.sv
module beep_ctrl
  import beep_pkg::*;
#(
  parameter int SHORT_PERIODS = 480,
  parameter int LONG_PERIODS  = 2400
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqShort,
  input  logic     reqLong,
  input  logic     periodDone,
  output toneCtl_t ctl,
  output logic     active
);

  localparam int MAX_PERIODS = (LONG_PERIODS > SHORT_PERIODS) ? LONG_PERIODS : SHORT_PERIODS;
  localparam int REM_W = $clog2(MAX_PERIODS + 1);
  localparam logic [REM_W-1:0] SHORT_LEN = REM_W'(SHORT_PERIODS);
  localparam logic [REM_W-1:0] LONG_LEN  = REM_W'(LONG_PERIODS);
  localparam logic [REM_W-1:0] ONE       = REM_W'(1);

  logic [REM_W-1:0] remCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      remCnt <= '0;
    end else if (reqLong) begin
      active <= 1'b1;
      remCnt <= LONG_LEN;
    end else if (reqShort) begin
      active <= 1'b1;
      remCnt <= SHORT_LEN;
    end else if (active && periodDone) begin
      if (remCnt == ONE) begin
        active <= 1'b0;
        remCnt <= '0;
      end else begin
        remCnt <= remCnt - 1'b1;
      end
    end
  end

  always_comb begin
    ctl.hold    = ~active;
    ctl.restart = reqShort | reqLong;
  end

  // R7 / R9: long request loads the long length, even alongside a short one
  assert_long_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqLong |=> (active && remCnt == LONG_LEN));

  // R6: short request alone loads the short length
  assert_short_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqShort && !reqLong) |=> (active && remCnt == SHORT_LEN));

  // R8: without a request the remaining count never grows
  assert_rem_no_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!reqShort && !reqLong) |=> remCnt <= $past(remCnt));

  // R10: any request keeps the beep alive in the next cycle
  assert_req_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqShort || reqLong) |=> active);

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
  import beep_pkg::*;
#(
  parameter int PRE_W         = 4,
  parameter int TONE_W        = 4,
  parameter int SHORT_PERIODS = 480,
  parameter int LONG_PERIODS  = 2400
) (
  input  logic clk,
  input  logic rstN,
  input  logic sysEn,
  input  logic reqShort,
  input  logic reqLong,
  output logic dispEn,
  output logic toneOut,
  output logic beepActive
);

  toneCtl_t toneCtl;
  logic     periodDone;

  beep_ctrl #(
    .SHORT_PERIODS (SHORT_PERIODS),
    .LONG_PERIODS  (LONG_PERIODS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqShort   (reqShort),
    .reqLong    (reqLong),
    .periodDone (periodDone),
    .ctl        (toneCtl),
    .active     (beepActive)
  );

  beep_tone_path #(
    .PRE_W  (PRE_W),
    .TONE_W (TONE_W)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .sysEn      (sysEn),
    .ctl        (toneCtl),
    .dispEn     (dispEn),
    .toneOut    (toneOut),
    .periodDone (periodDone)
  );

  // R4: silent whenever no beep is active
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !beepActive |-> !toneOut);

endmodule

// File: tb/beep_tone_gen_tb_top.sv
module beep_tone_gen_tb_top;

  localparam int SHORT_P = 3;
  localparam int LONG_P  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysEn = 1'b0, reqShort = 1'b0, reqLong = 1'b0;
  logic dispEn, toneOut, beepActive;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  string ctag = "R6";

  // reference model state
  int mPre = 0, mTone = 0, mRem = 0;
  bit mAct = 0;

  always #5 clk = ~clk;

  beep_tone_gen #(
    .PRE_W(4), .TONE_W(4), .SHORT_PERIODS(SHORT_P), .LONG_PERIODS(LONG_P)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sysEn(sysEn), .reqShort(reqShort), .reqLong(reqLong),
    .dispEn(dispEn), .toneOut(toneOut), .beepActive(beepActive)
  );

  function automatic bit expDisp(bit en, int pre);
    return en && (pre % 2 == 1);
  endfunction

  function automatic bit expTone(int tone);
    return tone >= 8;
  endfunction

  // true when this cycle ends the final tone period of the running beep
  function automatic bit finalWrap(bit en);
    return mAct && en && mPre == 15 && mTone == 15 && mRem == 1;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  task automatic modelUpdate(bit en, bit rs, bit rl);
    bit tick;
    tick = en && mPre == 15;
    if (en) mPre = (mPre + 1) % 16;
    if (rl) begin
      mAct = 1; mRem = LONG_P; mTone = 0;
    end else if (rs) begin
      mAct = 1; mRem = SHORT_P; mTone = 0;
    end else if (mAct && tick) begin
      if (mTone == 15) begin
        mTone = 0;
        if (mRem == 1) begin mAct = 0; mRem = 0; end
        else mRem--;
      end else begin
        mTone++;
      end
    end
  endtask

  task automatic step(bit en, bit rs, bit rl);
    @(negedge clk);
    sysEn = en; reqShort = rs; reqLong = rl;
    #1;
    if (rs || rl) chk("R2", dispEn, expDisp(en, mPre));
    else          chk("R1", dispEn, expDisp(en, mPre));
    if (!mAct)      chk("R4", toneOut, 1'b0);
    else if (!en)   chk("R3", toneOut, expTone(mTone));
    else            chk("R5", toneOut, expTone(mTone));
    chk(ctag, beepActive, mAct);
    @(posedge clk);
    cycles++;
    if (rstN) modelUpdate(en, rs, rl);
  endtask

  initial begin
    cycles = 0;
    while (cycles < 190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R11: reset state
    ctag = "R11";
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    chk("R11", beepActive, 1'b0);
    chk("R11", toneOut, 1'b0);
    @(negedge clk); rstN = 1'b1;
    step(1, 0, 0);
    chk("R11", dispEn, 1'b0);  // prescaler was cleared: first pulse is even

    // R6: short beep to completion
    ctag = "R6";
    step(1, 1, 0);
    for (int i = 0; i < 1000; i++) step(1, 0, 0);
    chk("R6", beepActive, 1'b0);

    // R7: long beep to completion
    ctag = "R7";
    step(1, 0, 1);
    for (int i = 0; i < 1500; i++) step(1, 0, 0);

    // R8: short restart in the middle of a long beep
    ctag = "R8";
    step(1, 0, 1);
    for (int i = 0; i < 300; i++) step(1, 0, 0);
    step(1, 1, 0);
    for (int i = 0; i < 900; i++) step(1, 0, 0);

    // R9: both requests together load the long length
    ctag = "R9";
    step(1, 1, 1);
    for (int i = 0; i < 1400; i++) step(1, 0, 0);

    // R10: request lands on the final wrap
    ctag = "R10";
    step(1, 1, 0);
    while (!finalWrap(1'b1)) step(1, 0, 0);
    step(1, 1, 0);
    chk("R10", beepActive, 1'b1);
    for (int i = 0; i < 1000; i++) step(1, 0, 0);

    // Random mix: sparse enables and requests
    ctag = "R8";
    for (int i = 0; i < 40000; i++) begin
      bit en, rs, rl;
      en = ($urandom % 4) != 0;
      rs = ($urandom % 900) == 0;
      rl = ($urandom % 1500) == 0;
      if (finalWrap(en) && ($urandom % 2 == 0)) rs = 1;
      step(en, rs, rl);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule